// File: doc/BRIEF.md
# Microsecond Interval Timer Pair

This block holds two identical up-counting interval timers behind a small register port. Each timer owns a 29-bit counter that advances by one on every pulse of an externally supplied 1 µs tick strobe. It also owns a 32-bit limit word that packs the limit value together with three control flags: interrupt enable, counter reload and periodic mode. When a counter reaches its limit on a tick, the timer signals an event. In periodic mode the counter wraps to zero on that event. In one-shot mode it parks at the limit.

The event sets a sticky per-timer interrupt line, provided interrupts are enabled for that timer. The line stays high until software writes any value to the timer's clear register. To get an interrupt every n ticks, software programs a limit of n−1. The counter then walks 0, 1, …, n−1 and wraps, so each interrupt is exactly n ticks after the last.

Registers are 64 bits wide on the bus. Writes take effect on the next clock edge. Reads are combinational from the current register state.

Top module: `tmr_interval_timer`

## Requirements
- R1: On a cycle with `tick` high and no register write to that timer, a counter that is not at its limit (or has not stopped) increments by one modulo 2^29, so 0x1FFFFFFF steps to 0; without `tick` the counter holds its value.
- R2: Limit-word bit 31 is the interrupt enable; a limit event on a timer whose bit 31 is 0 leaves its `irq` bit low.
- R3: Limit-word bit 30 is the reload flag; a limit write with bit 30 set forces that counter to 0, and a limit write with bit 30 clear leaves the counter value unchanged.
- R4: Limit-word bit 29 selects periodic mode; when a tick arrives while the counter equals the limit held in bits 28:0, the counter becomes 0 and a limit event occurs, so a limit of n−1 gives one event every n ticks.
- R5: With bit 29 clear (one-shot), the tick at which the counter equals the limit raises one event, after which the counter stays at the limit with no further events until the limit or count register is written.
- R6: `irq[i]` is sticky: set by an enabled limit event of timer i and cleared by a write of any data to that timer's clear register; an event in the same cycle as the clear wins and leaves `irq[i]` high.
- R7: The count register reads as the 29-bit count zero-extended to 64 bits; the limit register reads back bits 31:0 as last written with bits 63:32 as zero, and written bits 63:32 are discarded.
- R8: A write to the count register loads `bus_wdata[28:0]`; a register write in the same cycle as a tick takes priority over the tick.
- R9: `bus_addr[2]` selects timer 0 or 1 and `bus_addr[1:0]` selects count (0), limit (1), clear (2) or an unused slot (3); clear and unused slots read as zero, and each timer's state and `irq` bit are untouched by accesses to the other timer.
- R10: After reset both counters, both limit words and both `irq` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 µs strobe, one clock cycle wide per microsecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: bit 2 timer, bits 1:0 register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` (combinational) |
| irq | output | 2 | Sticky interrupt lines, one per timer |

## Verification
The counter is run in periodic mode with a five-tick period. This separates a correct n−1 encoding from an off-by-one period that wraps at n or n−2. Writes that coincide with ticks show whether a register write or the tick takes priority. A clear that lands on a limit event shows whether the event or the clear takes priority. One-shot runs past the limit show whether the counter parks or keeps counting, and whether the interrupt fires again after a clear. Programming the two timers with different periods and enables, then clearing one of them, shows any crosstalk between the timers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_LIMIT = 2'd1,
    REG_CLEAR = 2'd2,
    REG_SPARE = 2'd3
  } tmr_reg_e;

  // Control flag positions in the limit word, placed just above the count field.
  function automatic int per_pos(input int cnt_w);
    return cnt_w;
  endfunction

  function automatic int rld_pos(input int cnt_w);
    return cnt_w + 1;
  endfunction

  function automatic int ien_pos(input int cnt_w);
    return cnt_w + 2;
  endfunction

  function automatic int tsel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 29,
  parameter int LIM_W  = CNT_W + 3,
  parameter int TSEL_W = 1,
  parameter int DATA_W = 64
) (
  input  logic                            bus_wr,
  input  logic [TSEL_W+1:0]               bus_addr,
  input  logic [N_TMR-1:0][CNT_W-1:0]     cnt_rd,
  input  logic [N_TMR-1:0][LIM_W-1:0]     lim_rd,
  output logic [N_TMR-1:0]                wr_count,
  output logic [N_TMR-1:0]                wr_limit,
  output logic [N_TMR-1:0]                wr_clear,
  output logic [DATA_W-1:0]               rdata
);

  tmr_reg_e          sel;
  logic [TSEL_W-1:0] tidx;
  logic              tvalid;

  assign sel    = tmr_reg_e'(bus_addr[1:0]);
  assign tidx   = bus_addr[TSEL_W+1:2];
  assign tvalid = (int'(tidx) < N_TMR);

  for (genvar i = 0; i < N_TMR; i++) begin : g_strobe
    logic hit_me;
    assign hit_me      = bus_wr && tvalid && (tidx == TSEL_W'(i));
    assign wr_count[i] = hit_me && (sel == REG_COUNT);
    assign wr_limit[i] = hit_me && (sel == REG_LIMIT);
    assign wr_clear[i] = hit_me && (sel == REG_CLEAR);
  end

  always_comb begin
    rdata = '0;
    if (tvalid) begin
      case (sel)
        REG_COUNT: rdata[CNT_W-1:0] = cnt_rd[tidx];
        REG_LIMIT: rdata[LIM_W-1:0] = lim_rd[tidx];
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int LIM_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_count,
  input  logic             wr_limit,
  input  logic             wr_clear,
  input  logic [LIM_W-1:0] wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [LIM_W-1:0] limit_o,
  output logic             irq_o,
  output logic             hit_o,
  output logic             adv_o,
  output logic             reload_o,
  output logic             wr_any_o,
  output logic             periodic_o,
  output logic             ien_o
);

  localparam int P_PER = per_pos(CNT_W);
  localparam int P_RLD = rld_pos(CNT_W);
  localparam int P_IEN = ien_pos(CNT_W);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] lim_q;
  logic             per_q, rld_q, ien_q;
  logic             stopped_q;
  logic             irq_q;
  logic             wr_any, at_lim, live;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign wr_any = wr_count || wr_limit;
  assign at_lim = (count_q == lim_q);
  assign live   = tick && !wr_any && !stopped_q;
  assign hit_o  = live && at_lim;
  assign adv_o  = live && !at_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      lim_q     <= '0;
      per_q     <= 1'b0;
      rld_q     <= 1'b0;
      ien_q     <= 1'b0;
      stopped_q <= 1'b0;
    end else if (wr_limit) begin
      lim_q     <= wdata[CNT_W-1:0];
      per_q     <= wdata[P_PER];
      rld_q     <= wdata[P_RLD];
      ien_q     <= wdata[P_IEN];
      stopped_q <= 1'b0;
      if (wdata[P_RLD]) count_q <= '0;
    end else if (wr_count) begin
      count_q   <= wdata[CNT_W-1:0];
      stopped_q <= 1'b0;
    end else if (hit_o) begin
      if (per_q) count_q   <= '0;
      else       stopped_q <= 1'b1;
    end else if (adv_o) begin
      count_q <= step(count_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (hit_o && ien_q)   irq_q <= 1'b1;
    else if (wr_clear)         irq_q <= 1'b0;
  end

  assign count_o    = count_q;
  assign limit_o    = {ien_q, rld_q, per_q, lim_q};
  assign irq_o      = irq_q;
  assign reload_o   = wr_limit && wdata[P_RLD];
  assign wr_any_o   = wr_any;
  assign periodic_o = per_q;
  assign ien_o      = ien_q;

endmodule

// File: rtl/tmr_interval_timer.sv
module tmr_interval_timer
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 29,
  parameter int DATA_W = 64,
  parameter int TSEL_W = tsel_width(N_TMR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [TSEL_W+1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  irq
);

  localparam int LIM_W = CNT_W + 3;

  logic [N_TMR-1:0][CNT_W-1:0] cnt_rd;
  logic [N_TMR-1:0][LIM_W-1:0] lim_rd;
  logic [N_TMR-1:0] wr_count, wr_limit, wr_clear;
  logic [N_TMR-1:0] hit_w, adv_w, reload_w, wr_any_w, per_w, ien_w;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:LIM_W];

  tmr_bus_decode #(
    .N_TMR (N_TMR),
    .CNT_W (CNT_W),
    .LIM_W (LIM_W),
    .TSEL_W(TSEL_W),
    .DATA_W(DATA_W)
  ) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .cnt_rd  (cnt_rd),
    .lim_rd  (lim_rd),
    .wr_count(wr_count),
    .wr_limit(wr_limit),
    .wr_clear(wr_clear),
    .rdata   (bus_rdata)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    tmr_channel #(
      .CNT_W(CNT_W),
      .LIM_W(LIM_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_count  (wr_count[i]),
      .wr_limit  (wr_limit[i]),
      .wr_clear  (wr_clear[i]),
      .wdata     (bus_wdata[LIM_W-1:0]),
      .count_o   (cnt_rd[i]),
      .limit_o   (lim_rd[i]),
      .irq_o     (irq[i]),
      .hit_o     (hit_w[i]),
      .adv_o     (adv_w[i]),
      .reload_o  (reload_w[i]),
      .wr_any_o  (wr_any_w[i]),
      .periodic_o(per_w[i]),
      .ien_o     (ien_w[i])
    );
  end

endmodule

// File: rtl/tmr_interval_timer_chk.sv
module tmr_interval_timer_chk #(
  parameter int N_TMR = 2,
  parameter int CNT_W = 29
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic [N_TMR-1:0]            hit,
  input logic [N_TMR-1:0]            adv,
  input logic [N_TMR-1:0]            reload,
  input logic [N_TMR-1:0]            wr_any,
  input logic [N_TMR-1:0]            per,
  input logic [N_TMR-1:0]            ien,
  input logic [N_TMR-1:0]            clr,
  input logic [N_TMR-1:0]            irq,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt
);

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    // R1: an advancing tick moves the count up by exactly one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv[i] |=> cnt[i] == CNT_W'($past(cnt[i]) + CNT_W'(1)));

    // R1: no tick and no write leaves the count alone
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_any[i]) |=> $stable(cnt[i]));

    // R2: interrupt rises only after an enabled limit event
    a_r2_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(hit[i] && ien[i]));

    // R3: reload write zeroes the counter
    a_r3_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reload[i] |=> cnt[i] == '0);

    // R4: periodic limit event wraps to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && per[i]) |=> cnt[i] == '0);

    // R5: one-shot limit event parks the counter
    a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !per[i]) |=> $stable(cnt[i]));

    // R6: interrupt holds without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !clr[i]) |=> irq[i]);

    // R6: clear without a coinciding event drops the line
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !hit[i]) |=> !irq[i]);

    // R6: enabled event sets the line even against a clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && ien[i]) |=> irq[i]);
  end

endmodule

bind tmr_interval_timer tmr_interval_timer_chk #(
  .N_TMR(N_TMR),
  .CNT_W(CNT_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .hit   (hit_w),
  .adv   (adv_w),
  .reload(reload_w),
  .wr_any(wr_any_w),
  .per   (per_w),
  .ien   (ien_w),
  .clr   (wr_clear),
  .irq   (irq),
  .cnt   (cnt_rd)
);

// File: tb/tmr_interval_timer_tb.sv
`timescale 1ns/1ps
module tmr_interval_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tmr_interval_timer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  // Address map restated from R9
  localparam logic [2:0] A_CNT0 = 3'd0, A_LIM0 = 3'd1, A_CLR0 = 3'd2, A_SPR0 = 3'd3;
  localparam logic [2:0] A_CNT1 = 3'd4, A_LIM1 = 3'd5, A_CLR1 = 3'd6;

  function automatic logic [31:0] limit_word(bit en, bit rl, bit pd, int unsigned n_ticks);
    logic [28:0] v;
    v = 29'(n_ticks - 1);
    return {en, rl, pd, v};
  endfunction

  typedef struct {
    logic [63:0] exp;
    string       req;
    string       what;
  } item_t;

  item_t       sb_q[$];
  logic [63:0] obs;
  event        mon_ev;

  // Monitor: pops the expected item and compares with the observed value
  initial begin
    forever begin
      item_t it;
      @(mon_ev);
      it = sb_q.pop_front();
      checks++;
      if (obs !== it.exp) begin
        failures++;
        $display("FAIL %s %s: actual %h expected %h", it.req, it.what, obs, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [63:0] e, input string req, input string what);
    @(negedge clk);
    bus_addr = a;
    #1;
    obs = bus_rdata;
    sb_q.push_back('{exp: e, req: req, what: what});
    ->mon_ev;
    #1;
  endtask

  task automatic expect_irq(input int idx, input logic e, input string req);
    @(negedge clk);
    #1;
    obs = {63'd0, irq[idx]};
    sb_q.push_back('{exp: {63'd0, e}, req: req, what: $sformatf("irq[%0d]", idx)});
    ->mon_ev;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d, input bit with_tick);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    expect_reg(A_CNT0, 64'd0, "R10", "count0");
    expect_reg(A_LIM0, 64'd0, "R10", "limit0");
    expect_reg(A_CNT1, 64'd0, "R10", "count1");
    expect_reg(A_LIM1, 64'd0, "R10", "limit1");
    expect_irq(0, 1'b0, "R10");
    expect_irq(1, 1'b0, "R10");

    // R4 periodic, five-tick period
    wr(A_LIM0, {32'd0, limit_word(1, 0, 1, 5)}, 0);
    expect_reg(A_LIM0, 64'h0000_0000_A000_0004, "R7", "limit0 readback");
    ticks(3);
    expect_reg(A_CNT0, 64'd3, "R1", "count0 after 3 ticks");
    expect_irq(0, 1'b0, "R4");
    ticks(1);
    expect_reg(A_CNT0, 64'd4, "R4", "count0 at limit");
    expect_irq(0, 1'b0, "R4");
    ticks(1);
    expect_reg(A_CNT0, 64'd0, "R4", "count0 wrapped");
    expect_irq(0, 1'b1, "R4");
    expect_reg(A_CNT1, 64'd0, "R9", "count1 parked at zero limit");
    expect_irq(1, 1'b0, "R2");

    // R6 sticky and clear
    ticks(2);
    expect_irq(0, 1'b1, "R6");
    wr(A_CLR0, 64'hDEAD, 0);
    expect_irq(0, 1'b0, "R6");
    expect_reg(A_CNT0, 64'd2, "R6", "count0 unaffected by clear");
    ticks(2);
    expect_irq(0, 1'b0, "R4");
    ticks(1);
    expect_irq(0, 1'b1, "R4");
    expect_reg(A_CNT0, 64'd0, "R4", "count0 second wrap");

    // R6 event beats clear in the same cycle
    wr(A_CLR0, 64'd0, 0);
    expect_irq(0, 1'b0, "R6");
    wr(A_CNT0, 64'd4, 0);
    expect_reg(A_CNT0, 64'd4, "R8", "count0 loaded");
    wr(A_CLR0, 64'd0, 1);
    expect_irq(0, 1'b1, "R6");
    expect_reg(A_CNT0, 64'd0, "R4", "count0 wrap on collision");

    // R8 write beats tick, masking to 29 bits
    wr(A_CNT0, 64'hFFFF_FFFF_E000_0010, 1);
    expect_reg(A_CNT0, 64'h10, "R8", "count0 write over tick");
    ticks(1);
    expect_reg(A_CNT0, 64'h11, "R1", "count0 above limit advances");

    // R1 29-bit rollover
    wr(A_CNT0, 64'h1FFF_FFFF, 0);
    ticks(1);
    expect_reg(A_CNT0, 64'd0, "R1", "count0 rollover");

    // R3 reload flag
    ticks(2);
    wr(A_LIM0, {32'd0, limit_word(1, 0, 0, 5)}, 0);
    expect_reg(A_CNT0, 64'd2, "R3", "count0 kept without reload");
    wr(A_LIM0, {32'd0, limit_word(1, 1, 0, 5)}, 0);
    expect_reg(A_CNT0, 64'd0, "R3", "count0 reloaded");
    expect_reg(A_LIM0, 64'h0000_0000_C000_0004, "R7", "limit0 reload bit readback");

    // R5 one-shot
    wr(A_CLR0, 64'd0, 0);
    expect_irq(0, 1'b0, "R6");
    ticks(4);
    expect_reg(A_CNT0, 64'd4, "R5", "count0 reaches limit");
    expect_irq(0, 1'b0, "R5");
    ticks(1);
    expect_irq(0, 1'b1, "R5");
    expect_reg(A_CNT0, 64'd4, "R5", "count0 parked");
    wr(A_CLR0, 64'd0, 0);
    ticks(3);
    expect_reg(A_CNT0, 64'd4, "R5", "count0 still parked");
    expect_irq(0, 1'b0, "R5");
    wr(A_LIM0, {32'd0, limit_word(1, 0, 0, 7)}, 0);
    expect_reg(A_CNT0, 64'd4, "R5", "count0 after rewrite");
    ticks(1);
    expect_reg(A_CNT0, 64'd5, "R5", "count0 resumes");

    // R2 enable gating on timer 1, R9 independence
    wr(A_LIM0, {32'd0, limit_word(0, 1, 0, 1)}, 0);
    expect_reg(A_CNT0, 64'd0, "R3", "count0 reloaded again");
    wr(A_LIM1, {32'd0, limit_word(0, 0, 1, 3)}, 0);
    ticks(3);
    expect_reg(A_CNT1, 64'd0, "R4", "count1 wrapped");
    expect_irq(1, 1'b0, "R2");
    expect_irq(0, 1'b0, "R9");
    wr(A_LIM1, {32'd0, limit_word(1, 0, 1, 3)}, 0);
    ticks(2);
    expect_irq(1, 1'b0, "R4");
    ticks(1);
    expect_irq(1, 1'b1, "R2");
    expect_irq(0, 1'b0, "R9");

    // R7 upper bits discarded, R9 spare and clear slots
    wr(A_LIM1, {32'hFFFF_FFFF, limit_word(1, 0, 1, 3)}, 0);
    expect_reg(A_LIM1, 64'h0000_0000_A000_0002, "R7", "limit1 upper bits dropped");
    expect_reg(A_SPR0, 64'd0, "R9", "spare slot");
    expect_reg(A_CLR1, 64'd0, "R9", "clear slot read");
    wr(A_CLR0, 64'd0, 0);
    expect_irq(1, 1'b1, "R9");
    wr(A_CLR1, 64'd0, 0);
    expect_irq(1, 1'b0, "R6");
    expect_irq(0, 1'b0, "R9");

    @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule